// File: doc/BRIEF.md
# Offset Calibration Sequencer

This block sits on the output of a decimating filter. It runs a self-offset calibration and then corrects the filter's output words. A calibration request that goes from low to high arms the sequencer. The next SYNC pulse starts the calibration. The sequencer then counts output-word strobes while the filter settles on its input, which must present the offset condition.

After 56 settling words, the 57th word is the offset sample. On that word the sequencer:
- passes the word straight through,
- marks it with a one-cycle done flag,
- stores it in the offset register.

Outside a calibration, each word can have the stored offset subtracted, with saturation, under control of a use-offset input. The filter itself and its rate selection are outside this block.

Top module: `ofs_cal_seq`

## Requirements
- R1: A rising edge of `cal_req` arms the sequencer. The calibration starts on the first `sync_in` high that is sampled in a cycle after the arming cycle. A `sync_in` pulse while the sequencer is not armed starts nothing.
- R2: After the start, the sequencer counts strobed words on `word_vld`, beginning in the cycle after the start. On the 57th strobed word (SETTLE_WORDS = 56 settling words, then one more), `cal_done` is 1 for exactly one cycle, together with `out_vld`, and `out_word` equals that input word. No earlier word of the calibration raises `cal_done`.
- R3: The 57th word of a calibration is loaded into the offset register. Later words with `use_ofs` = 1 have this value subtracted.
- R4: From the start through the 57th word, output words equal the input words, whatever the value of `use_ofs`.
- R5: Outside a calibration, `use_ofs` = 1 gives `out_word` = `word_in` − offset. `use_ofs` = 0 gives `out_word` = `word_in`. Neither setting changes the stored offset.
- R6: The subtraction is 24-bit two's complement. A result above 0x7FFFFF saturates to 0x7FFFFF, and a result below 0x800000 saturates to 0x800000. A result exactly at a limit is not altered.
- R7: The stored offset changes only when a calibration completes or on reset.
- R8: Re-arming requires one clock with both `cal_req` and `sync_in` low, followed by a rise of `cal_req`. If `cal_req` was low only in cycles where `sync_in` was high, its rise does not arm.
- R9: If `cal_req` stays high, only one calibration runs. Later SYNC pulses start nothing.
- R10: If `cal_req` is high when `rst_n` is released, the sequencer is armed, and the next SYNC starts a calibration.
- R11: Reset (`rst_n` low) does all of the following:
  - clears the offset to zero,
  - drives `cal_done` and `out_vld` to 0,
  - returns the sequencer to idle.
- R12: Each strobed word appears on `out_word` with `out_vld` = 1 one clock after it is sampled. With no strobe, `out_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_vld | input | 1 | Output-word strobe from the filter |
| word_in | input | 24 | Filter output word, two's complement |
| sync_in | input | 1 | SYNC event, high for one or more cycles |
| cal_req | input | 1 | Calibration request; armed on its rising edge |
| use_ofs | input | 1 | Subtract the stored offset when 1 |
| out_vld | output | 1 | Corrected word valid |
| out_word | output | 24 | Corrected or passed-through word |
| cal_done | output | 1 | Marks the offset sample word |

## Verification
The hardest situation to reach from the ports is a refused re-arm. In that case the request falls and rises again, but the rise must not arm because SYNC was high during every low cycle of the request. The stimulus raises SYNC first, drops the request for one cycle under it, raises the request, and only then releases SYNC. It then issues a clean SYNC pulse and streams more than 57 words, checking that no done flag appears. A second hard case is the passthrough during a calibration, which only shows when a nonzero offset is already stored. For this reason the bench runs its second calibration with the first offset still in place and `use_ofs` held high.

// File: rtl/ofs_cal_pkg.sv
package ofs_cal_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ARMED = 2'd1,
    SQ_RUN   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ofs_arm.sv
// Turns the request level into a single arming event, with re-arm qualification.
module ofs_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_req,
  input  logic sync_in,
  output logic arm_evt
);
  logic req_q;     // reset to 0, so a high request at release counts as a rise
  logic rearm_ok;  // a qualifying low cycle (req and sync low) has been seen

  assign arm_evt = cal_req && !req_q && rearm_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      rearm_ok <= 1'b1;
    end else begin
      req_q <= cal_req;
      if (arm_evt)
        rearm_ok <= 1'b0;
      else if (!cal_req && !sync_in)
        rearm_ok <= 1'b1;
    end
  end

  AST_ARM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    arm_evt |=> !arm_evt); // R9
endmodule

// File: rtl/ofs_seq.sv
// Calibration state machine and settling-word counter.
module ofs_seq #(
  parameter int SETTLE_WORDS = 56
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_evt,
  input  logic sync_in,
  input  logic word_vld,
  output logic running,
  output logic last_word
);
  import ofs_cal_pkg::*;
  localparam int CNT_W = $clog2(SETTLE_WORDS + 1);

  seq_state_e st_q;
  logic [CNT_W-1:0] cnt_q;

  assign running   = (st_q == SQ_RUN);
  assign last_word = running && word_vld && (cnt_q == CNT_W'(SETTLE_WORDS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE:  if (arm_evt) st_q <= SQ_ARMED;
        SQ_ARMED: if (sync_in) begin
          st_q  <= SQ_RUN;
          cnt_q <= '0;
        end
        SQ_RUN: if (word_vld) begin
          if (last_word) st_q <= SQ_IDLE;
          else           cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  AST_START_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_ARMED && sync_in) |=> running); // R1
  AST_RUN_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(sync_in)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(SETTLE_WORDS)); // R2
  AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |=> !running); // R2
endmodule

// File: rtl/ofs_apply.sv
// Offset register, saturating subtraction and output registers.
module ofs_apply #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic [DATA_W-1:0] word_in,
  input  logic              use_ofs,
  input  logic              running,
  input  logic              load,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_word,
  output logic              cal_done
);
  localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic [DATA_W-1:0] sat_sub(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    logic [DATA_W:0] d;
    d = {a[DATA_W-1], a} - {b[DATA_W-1], b};
    if (d[DATA_W] != d[DATA_W-1]) return d[DATA_W] ? NEG_LIM : POS_LIM;
    return d[DATA_W-1:0];
  endfunction

  logic [DATA_W-1:0] ofs_q;
  logic [DATA_W-1:0] next_word;

  assign next_word = (running || !use_ofs) ? word_in : sat_sub(word_in, ofs_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_q    <= '0;
      out_vld  <= 1'b0;
      out_word <= '0;
      cal_done <= 1'b0;
    end else begin
      out_vld  <= word_vld;
      cal_done <= load;
      if (word_vld) out_word <= next_word;
      if (load)     ofs_q    <= word_in;
    end
  end

  AST_DONE_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> out_vld); // R2
  AST_DONE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (out_word == ofs_q)); // R3
  AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ofs_q)); // R7
  AST_BYPASS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && running) |=> (out_word == $past(word_in))); // R4
  AST_PASS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !use_ofs) |=> (out_word == $past(word_in))); // R5
endmodule

// File: rtl/ofs_cal_seq.sv
module ofs_cal_seq #(
  parameter int DATA_W       = 24,
  parameter int SETTLE_WORDS = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic [DATA_W-1:0] word_in,
  input  logic              sync_in,
  input  logic              cal_req,
  input  logic              use_ofs,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_word,
  output logic              cal_done
);
  logic arm_evt;
  logic running;
  logic last_word;

  ofs_arm u_arm (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .sync_in(sync_in),
    .arm_evt(arm_evt)
  );

  ofs_seq #(.SETTLE_WORDS(SETTLE_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .arm_evt(arm_evt), .sync_in(sync_in),
    .word_vld(word_vld), .running(running), .last_word(last_word)
  );

  ofs_apply #(.DATA_W(DATA_W)) u_apply (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(word_in),
    .use_ofs(use_ofs), .running(running), .load(last_word),
    .out_vld(out_vld), .out_word(out_word), .cal_done(cal_done)
  );

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == $past(word_vld)); // R12
endmodule

// File: tb/ofs_cal_seq_tb.sv
module ofs_cal_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_vld = 1'b0;
  logic [23:0] word_in = '0;
  logic        sync_in = 1'b0;
  logic        cal_req = 1'b0;
  logic        use_ofs = 1'b0;
  logic        out_vld;
  logic [23:0] out_word;
  logic        cal_done;

  int n_run = 0;
  int n_fail = 0;
  int dones = 0;
  logic [23:0] o_word;
  logic        o_vld;
  logic        o_done;

  always #2 clk = ~clk;

  ofs_cal_seq u_dut (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(word_in),
    .sync_in(sync_in), .cal_req(cal_req), .use_ofs(use_ofs),
    .out_vld(out_vld), .out_word(out_word), .cal_done(cal_done)
  );

  // {use_ofs, input word, expected output} with offset 0x000100 stored
  localparam logic [48:0] VEC [8] = '{
    {1'b1, 24'h0003E8, 24'h0002E8},
    {1'b0, 24'h0003E8, 24'h0003E8},
    {1'b1, 24'h800000, 24'h800000},
    {1'b1, 24'h800050, 24'h800000},
    {1'b1, 24'h800100, 24'h800000},
    {1'b1, 24'h7FFFFF, 24'h7FFEFF},
    {1'b1, 24'h000000, 24'hFFFF00},
    {1'b0, 24'h800000, 24'h800000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one strobed word, observe the registered result one clock later
  task automatic send_word(input logic [23:0] d, input logic u);
    @(negedge clk);
    word_vld = 1'b1; word_in = d; use_ofs = u;
    @(negedge clk);
    word_vld = 1'b0;
    o_word = out_word; o_vld = out_vld; o_done = cal_done;
    if (o_done) dones++;
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
  endtask

  task automatic stream(input int n, input logic [23:0] d, input logic u,
                        input logic [23:0] exp, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      send_word(d, u);
      if (o_word !== exp || o_vld !== 1'b1) bad++;
    end
    chk(bad == 0, req, 32'(bad), 32'd0);
  endtask

  // 56 settling words, then the sample word
  task automatic run_cal(input logic [23:0] sample, input string req);
    dones = 0;
    stream(56, 24'h000005, 1'b1, 24'h000005, "R4 passthrough while settling");
    chk(dones == 0, "R2 no early done", 32'(dones), 32'd0);
    send_word(sample, 1'b1);
    chk(o_done === 1'b1, req, 32'(o_done), 32'd1);
    chk(o_word === sample, "R2 sample passed through", 32'(o_word), 32'(sample));
    @(negedge clk);
    chk(cal_done === 1'b0, "R2 done one cycle", 32'(cal_done), 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_vld === 1'b0 && cal_done === 1'b0, "R11 reset outputs",
        32'({out_vld, cal_done}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_vld === 1'b0, "R12 no strobe no valid", 32'(out_vld), 32'd0);

    // R1: SYNC while not armed does nothing
    pulse_sync();
    dones = 0;
    stream(60, 24'h000010, 1'b1, 24'h000010, "R11 zero offset after reset");
    chk(dones == 0, "R1 unarmed sync ignored", 32'(dones), 32'd0);

    // R1: arm, words before SYNC do not count
    @(negedge clk); cal_req = 1'b1;
    dones = 0;
    stream(10, 24'h000007, 1'b1, 24'h000007, "R12 pre-sync words");
    chk(dones == 0, "R1 no start without sync", 32'(dones), 32'd0);
    pulse_sync();
    run_cal(24'h000100, "R2 done on 57th word");

    // R3 R5 R6: table walk with offset 0x100
    foreach (VEC[i]) begin
      send_word(VEC[i][47:24], VEC[i][48]);
      chk(o_word === VEC[i][23:0] && o_vld === 1'b1, "R6 table vector",
          32'(o_word), 32'(VEC[i][23:0]));
    end

    // R9: request held high, another SYNC starts nothing; R7 offset kept
    pulse_sync();
    dones = 0;
    stream(60, 24'h0003E8, 1'b1, 24'h0002E8, "R7 offset held");
    chk(dones == 0, "R9 single calibration", 32'(dones), 32'd0);

    // R8: request low only while SYNC high, rise must not arm
    @(negedge clk); sync_in = 1'b1; cal_req = 1'b0;
    @(negedge clk); cal_req = 1'b1;
    @(negedge clk); sync_in = 1'b0;
    pulse_sync();
    dones = 0;
    stream(60, 24'h0003E8, 1'b1, 24'h0002E8, "R5 offset applied");
    chk(dones == 0, "R8 unqualified rise ignored", 32'(dones), 32'd0);

    // R8: proper re-arm, new calibration with negative offset
    @(negedge clk); cal_req = 1'b0;
    @(negedge clk); cal_req = 1'b1;
    pulse_sync();
    run_cal(24'hFFFF00, "R8 re-armed calibration done");
    send_word(24'h7FFF80, 1'b1);
    chk(o_word === 24'h7FFFFF, "R6 positive saturation", 32'(o_word), 32'h7FFFFF);
    send_word(24'h7FFEFF, 1'b1);
    chk(o_word === 24'h7FFFFF, "R6 exact positive limit", 32'(o_word), 32'h7FFFFF);
    send_word(24'h000000, 1'b1);
    chk(o_word === 24'h000100, "R3 new offset used", 32'(o_word), 32'h000100);

    // R10 R11: reset with request high
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(cal_done === 1'b0 && out_vld === 1'b0, "R11 reset mid-run",
        32'({out_vld, cal_done}), 32'd0);
    rst_n = 1'b1;
    send_word(24'h0003E8, 1'b1);
    chk(o_word === 24'h0003E8, "R11 offset cleared", 32'(o_word), 32'h0003E8);
    pulse_sync();
    run_cal(24'h000042, "R10 armed by high request at reset");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule